// File: doc/BRIEF.md
# UART Host Register File

This block is the register front end of a 16550-style serial port. It sits between an 8-bit host bus with three offset lines and the serial datapath. It holds the line, modem, interrupt-enable, FIFO and divisor settings and drives them out as plain configuration pins. On reads it assembles line status, modem status and interrupt identification from datapath inputs. Bit 7 of the line control byte selects a second bank, which puts the two divisor bytes at offsets 0 and 1 in place of the data port and the interrupt enable.

Offset 0 moves bytes between the host and the datapath. The transmit side is a valid/ready source. A write with the bank bit clear loads a one-byte holding stage and raises `tx_valid`. The stage drops `tx_valid` after the first cycle in which `tx_ready` is high. While the stage waits, `tx_data` does not change unless the host writes again. Such a write replaces the waiting byte. The host avoids this by checking the holding-free bit in line status first.

The receive side is a valid/ready sink. A read with the bank bit clear returns `rx_data` in the same cycle and raises `rx_ready` for that one cycle. A byte is consumed only when `rx_valid` is also high. The block also owns the loopback switch and the break override on the serial pins.

Top module: `sio_hostregs`

## Requirements
- R1: After reset, offsets 1, 3, 4, 6 and 7 read 0x00, and both divisor bytes read 0x00. Offset 5 reads 0x60 when `tx_ready`=1, `tx_idle`=1 and `rx_valid`=0. Offset 2 reads 0x01 and `irq` is low.
- R2: With control bit 7 at 1, offset 0 accesses the low divisor byte and offset 1 the high byte, and `divisor` = {high, low}. With bit 7 at 0, offset 0 is the data port and offset 1 is the interrupt enable.
- R3: A write to offset 0 with the bank bit clear raises `tx_valid` with `tx_data` = the written byte on the next cycle. `tx_valid` stays high with stable data until a cycle with `tx_ready` high, and then drops. A write to offset 0 with the bank bit set pushes nothing.
- R4: A read of offset 0 with the bank bit clear returns `rx_data` and raises `rx_ready` in that cycle. `rx_ready` is low for every other access.
- R5: A write to offset 2 sets `fifo_en` from bit 0 and `rx_trig` from bits 7:6. Bits 1 and 2 raise `rx_flush` and `tx_flush` for one cycle. A read of offset 2 returns interrupt identification, with bits 7:6 = 11 while `fifo_en` is set.
- R6: Offsets 3, 4 and 7 read back what was written (offset 4 holds 5 bits). Line control bits 1:0 drive `char_len`, bit 2 `stop_two`, bit 3 `par_en`, bit 4 `par_even`, bit 5 `par_stick` and bit 6 `brk`. Modem control bits 3:0 drive `modem_ctl`.
- R7: Writes to offsets 5 and 6 change no register, no status and no output.
- R8: Line status is {`rx_fifo_err`, holding free and `tx_idle`, holding free, error flags 3:0, `rx_valid`}. Holding free is `tx_ready` with no byte waiting. Each `rx_err` pulse sets its flag (bit 0 overrun, 1 parity, 2 framing, 3 break). A read of offset 5 clears the flags.
- R9: Modem status bits 7:4 show the levels {dcd, ri, dsr, cts}. Bits 0, 1 and 3 flag any change of cts, dsr and dcd. Bit 2 flags ri falling. A read of offset 6 clears the flags.
- R10: With modem control bit 4 set, `ser_txd` is 1 and `ser_rx_int` follows `ser_tx_int`. `modem_ctl` is 0. The status levels come from modem control: cts from bit 1, dsr from bit 0, ri from bit 2 and dcd from bit 3.
- R11: With loopback off, `ser_rx_int` follows `ser_rxd`. `ser_txd` follows `ser_tx_int`, except that line control bit 6 forces it to 0.
- R12: Offset 2 bits 3:0 read 0110 for pending line errors, 0100 for receive data, 0010 for holding free and 0000 for modem change, in that priority order. Each source is gated by interrupt enable bits 2, 0, 1 and 3 in turn. With nothing pending it reads 0001 and `irq` is low; otherwise `irq` is high.
- R13: The interrupt enable keeps bits 3:0 only; bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_ready | input | 1 | Datapath accepts a transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_idle | input | 1 | Serializer empty |
| rx_valid | input | 1 | Receive byte available |
| rx_ready | output | 1 | Receive pop strobe |
| rx_data | input | 8 | Receive byte |
| rx_err | input | 4 | Error pulses: break, framing, parity, overrun (bit 0) |
| rx_fifo_err | input | 1 | Error present somewhere in receive queue |
| fifo_en | output | 1 | Queues enabled |
| rx_flush | output | 1 | Receive queue clear pulse |
| tx_flush | output | 1 | Transmit queue clear pulse |
| rx_trig | output | 2 | Receive trigger level code |
| divisor | output | 16 | Baud divisor |
| char_len | output | 2 | Character length code |
| stop_two | output | 1 | Long stop select |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity select |
| brk | output | 1 | Break request |
| modem_in | input | 4 | Modem levels {dcd, ri, dsr, cts} |
| modem_ctl | output | 4 | Modem outputs {out2, out1, rts, dtr} |
| ser_tx_int | input | 1 | Serializer output |
| ser_txd | output | 1 | External serial output |
| ser_rxd | input | 1 | External serial input |
| ser_rx_int | output | 1 | Deserializer input |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bank bit or a corrupted stored byte shows on the very next read of the affected offset. The configuration pins (`divisor`, line fields, `modem_ctl`) expose it the cycle after the faulty write. A stuck error or change flag in the status logic does not show at once. It appears as a status byte or identification code that fails to clear on the following read. It also appears as `irq` staying high after the clearing read, so the bench reads every sticky source twice. A holding-stage fault shows as `tx_valid` outlasting or preceding its accept cycle by one clock.

// File: rtl/sio_hostregs_pkg.sv
package sio_hostregs_pkg;
  localparam int REG_W  = 8;
  localparam int OFS_W  = 3;
  localparam int N_OFS  = 1 << OFS_W;
  localparam int DIV_W  = 2 * REG_W;
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;
  localparam int N_ERR  = 4;
  localparam int N_MDM  = 4;

  localparam int BANK_BIT  = 7;
  localparam int BRK_BIT   = 6;
  localparam int LOOP_BIT  = 4;
  localparam int QEN_BIT   = 0;
  localparam int RXCLR_BIT = 1;
  localparam int TXCLR_BIT = 2;

  // index of the ring-indicate line inside the modem level vector
  localparam int RING_IDX = 2;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IDQC  = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SPARE = 3'd7
  } ofs_e;

  typedef struct packed {
    logic rx_pop;
    logic tx_push;
    logic ien_wr;
    logic dlo_wr;
    logic dhi_wr;
    logic qctl_wr;
    logic lctl_wr;
    logic mctl_wr;
    logic spare_wr;
    logic lstat_rd;
    logic mstat_rd;
  } acc_t;

  localparam logic [2:0] ID_LINE  = 3'b011;
  localparam logic [2:0] ID_RXD   = 3'b010;
  localparam logic [2:0] ID_THRE  = 3'b001;
  localparam logic [2:0] ID_MODEM = 3'b000;
endpackage

// File: rtl/sio_hostregs_decode.sv
module sio_hostregs_decode
  import sio_hostregs_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  input  logic             wr,
  input  logic             rd,
  input  logic             bank,
  output acc_t             acc
);
  logic [N_OFS-1:0] wr_hit;
  logic [N_OFS-1:0] rd_hit;

  for (genvar i = 0; i < N_OFS; i++) begin : g_hit
    assign wr_hit[i] = wr && (addr == OFS_W'(i));
    assign rd_hit[i] = rd && (addr == OFS_W'(i));
  end

  always_comb begin
    acc          = '0;
    acc.rx_pop   = rd_hit[OFS_DATA] && !bank;
    acc.tx_push  = wr_hit[OFS_DATA] && !bank;
    acc.dlo_wr   = wr_hit[OFS_DATA] && bank;
    acc.ien_wr   = wr_hit[OFS_IEN]  && !bank;
    acc.dhi_wr   = wr_hit[OFS_IEN]  && bank;
    acc.qctl_wr  = wr_hit[OFS_IDQC];
    acc.lctl_wr  = wr_hit[OFS_LCTL];
    acc.mctl_wr  = wr_hit[OFS_MCTL];
    acc.spare_wr = wr_hit[OFS_SPARE];
    acc.lstat_rd = rd_hit[OFS_LSTAT];
    acc.mstat_rd = rd_hit[OFS_MSTAT];
  end
endmodule

// File: rtl/sio_hostregs_status.sv
module sio_hostregs_status
  import sio_hostregs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err_pulse,
  input  logic             err_clr,
  input  logic [N_MDM-1:0] mdm_lvl,
  input  logic             mdm_clr,
  output logic [N_ERR-1:0] err_flag,
  output logic [N_MDM-1:0] mdm_chg
);
  logic [N_MDM-1:0] lvl_prev;
  logic [N_MDM-1:0] chg_evt;

  for (genvar i = 0; i < N_MDM; i++) begin : g_evt
    if (i == RING_IDX) begin : g_fall
      assign chg_evt[i] = lvl_prev[i] && !mdm_lvl[i];
    end else begin : g_any
      assign chg_evt[i] = lvl_prev[i] != mdm_lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= '0;
      mdm_chg  <= '0;
      lvl_prev <= '0;
    end else begin
      lvl_prev <= mdm_lvl;
      err_flag <= (err_clr ? '0 : err_flag) | err_pulse;
      mdm_chg  <= (mdm_clr ? '0 : mdm_chg) | chg_evt;
    end
  end
endmodule

// File: rtl/sio_hostregs_irq.sv
module sio_hostregs_irq
  import sio_hostregs_pkg::*;
(
  input  logic [IEN_W-1:0] ien,
  input  logic             src_line,
  input  logic             src_rxd,
  input  logic             src_thre,
  input  logic             src_modem,
  input  logic             qen,
  output logic [REG_W-1:0] ident,
  output logic             irq
);
  logic [2:0] id;
  logic       pend;

  always_comb begin
    pend = 1'b1;
    id   = ID_MODEM;
    if (src_line && ien[2])       id = ID_LINE;
    else if (src_rxd && ien[0])   id = ID_RXD;
    else if (src_thre && ien[1])  id = ID_THRE;
    else if (src_modem && ien[3]) id = ID_MODEM;
    else                          pend = 1'b0;
  end

  assign irq   = pend;
  assign ident = {qen, qen, 2'b00, id, !pend};
endmodule

// File: rtl/sio_hostregs.sv
module sio_hostregs
  import sio_hostregs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [REG_W-1:0] tx_data,
  input  logic             tx_idle,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [REG_W-1:0] rx_data,
  input  logic [N_ERR-1:0] rx_err,
  input  logic             rx_fifo_err,
  output logic             fifo_en,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic [1:0]       rx_trig,
  output logic [DIV_W-1:0] divisor,
  output logic [1:0]       char_len,
  output logic             stop_two,
  output logic             par_en,
  output logic             par_even,
  output logic             par_stick,
  output logic             brk,
  input  logic [N_MDM-1:0] modem_in,
  output logic [N_MDM-1:0] modem_ctl,
  input  logic             ser_tx_int,
  output logic             ser_txd,
  input  logic             ser_rxd,
  output logic             ser_rx_int,
  output logic             irq
);
  logic [IEN_W-1:0]  ien_q;
  logic [REG_W-1:0]  lctl_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [REG_W-1:0]  spare_q;
  logic [REG_W-1:0]  dlo_q;
  logic [REG_W-1:0]  dhi_q;
  logic              qen_q;
  logic [1:0]        trig_q;
  logic              rxclr_q;
  logic              txclr_q;
  logic              hold_q;
  logic [REG_W-1:0]  hold_data_q;

  acc_t              acc;
  logic [N_ERR-1:0]  err_flag;
  logic [N_MDM-1:0]  mdm_chg;
  logic [N_MDM-1:0]  mdm_lvl;
  logic [REG_W-1:0]  ident;
  logic [REG_W-1:0]  lstat;
  logic [REG_W-1:0]  mstat;
  logic              bank;
  logic              loop_on;
  logic              hold_free;

  assign bank    = lctl_q[BANK_BIT];
  assign loop_on = mctl_q[LOOP_BIT];

  sio_hostregs_decode u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .bank (bank),
    .acc  (acc)
  );

  // configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      lctl_q  <= '0;
      mctl_q  <= '0;
      spare_q <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      qen_q   <= 1'b0;
      trig_q  <= '0;
      rxclr_q <= 1'b0;
      txclr_q <= 1'b0;
    end else begin
      if (acc.ien_wr)   ien_q   <= bus_wdata[IEN_W-1:0];
      if (acc.lctl_wr)  lctl_q  <= bus_wdata;
      if (acc.mctl_wr)  mctl_q  <= bus_wdata[MCTL_W-1:0];
      if (acc.spare_wr) spare_q <= bus_wdata;
      if (acc.dlo_wr)   dlo_q   <= bus_wdata;
      if (acc.dhi_wr)   dhi_q   <= bus_wdata;
      if (acc.qctl_wr) begin
        qen_q  <= bus_wdata[QEN_BIT];
        trig_q <= bus_wdata[REG_W-1 -: 2];
      end
      rxclr_q <= acc.qctl_wr && bus_wdata[RXCLR_BIT];
      txclr_q <= acc.qctl_wr && bus_wdata[TXCLR_BIT];
    end
  end

  // one-byte transmit holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      hold_data_q <= '0;
    end else if (acc.tx_push) begin
      hold_q      <= 1'b1;
      hold_data_q <= bus_wdata;
    end else if (tx_ready) begin
      hold_q      <= 1'b0;
    end
  end

  assign hold_free = tx_ready && !hold_q;

  // modem levels: looped from the control byte or taken from the pins
  assign mdm_lvl = loop_on ? {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1]} : modem_in;

  sio_hostregs_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse (rx_err),
    .err_clr   (acc.lstat_rd),
    .mdm_lvl   (mdm_lvl),
    .mdm_clr   (acc.mstat_rd),
    .err_flag  (err_flag),
    .mdm_chg   (mdm_chg)
  );

  assign lstat = {rx_fifo_err, hold_free && tx_idle, hold_free, err_flag, rx_valid};
  assign mstat = {mdm_lvl, mdm_chg};

  sio_hostregs_irq u_irq (
    .ien       (ien_q),
    .src_line  (|err_flag),
    .src_rxd   (rx_valid),
    .src_thre  (hold_free),
    .src_modem (|mdm_chg),
    .qen       (qen_q),
    .ident     (ident),
    .irq       (irq)
  );

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_DATA:  bus_rdata = bank ? dlo_q : rx_data;
        OFS_IEN:   bus_rdata = bank ? dhi_q : {{(REG_W-IEN_W){1'b0}}, ien_q};
        OFS_IDQC:  bus_rdata = ident;
        OFS_LCTL:  bus_rdata = lctl_q;
        OFS_MCTL:  bus_rdata = {{(REG_W-MCTL_W){1'b0}}, mctl_q};
        OFS_LSTAT: bus_rdata = lstat;
        OFS_MSTAT: bus_rdata = mstat;
        OFS_SPARE: bus_rdata = spare_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign rx_ready   = acc.rx_pop;
  assign tx_valid   = hold_q;
  assign tx_data    = hold_data_q;
  assign fifo_en    = qen_q;
  assign rx_flush   = rxclr_q;
  assign tx_flush   = txclr_q;
  assign rx_trig    = trig_q;
  assign divisor    = {dhi_q, dlo_q};
  assign char_len   = lctl_q[1:0];
  assign stop_two   = lctl_q[2];
  assign par_en     = lctl_q[3];
  assign par_even   = lctl_q[4];
  assign par_stick  = lctl_q[5];
  assign brk        = lctl_q[BRK_BIT];
  assign modem_ctl  = loop_on ? '0 : mctl_q[N_MDM-1:0];
  assign ser_txd    = loop_on ? 1'b1 : (ser_tx_int && !lctl_q[BRK_BIT]);
  assign ser_rx_int = loop_on ? ser_tx_int : ser_rxd;
endmodule

// File: rtl/sio_hostregs_chk.sv
module sio_hostregs_chk
  import sio_hostregs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [REG_W-1:0] bus_wdata,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [REG_W-1:0] tx_data,
  input logic             rx_ready,
  input logic             rx_flush,
  input logic [N_ERR-1:0] rx_err,
  input logic             ser_txd,
  input logic             ser_tx_int,
  input logic             ser_rx_int,
  input logic [REG_W-1:0] lctl_q,
  input logic [MCTL_W-1:0] mctl_q,
  input logic [IEN_W-1:0] ien_q,
  input logic [REG_W-1:0] spare_q,
  input logic [REG_W-1:0] dlo_q,
  input logic [REG_W-1:0] dhi_q,
  input logic [N_ERR-1:0] err_flag
);
  logic tx_wr;
  assign tx_wr = bus_wr && (bus_addr == OFS_DATA) && !lctl_q[BANK_BIT];

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_wr) |=> (tx_valid && $stable(tx_data)));

  assert_bank_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA && lctl_q[BANK_BIT] && !tx_valid) |=> !tx_valid);

  assert_pop_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_rd && bus_addr == OFS_DATA && !lctl_q[BANK_BIT]));

  assert_flush_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> ($past(bus_wr) && $past(bus_addr) == OFS_IDQC && $past(bus_wdata[RXCLR_BIT])));

  assert_ro_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_LSTAT || bus_addr == OFS_MSTAT)) |=>
      ($stable(lctl_q) && $stable(mctl_q) && $stable(ien_q) && $stable(spare_q)
       && $stable(dlo_q) && $stable(dhi_q)));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_LSTAT && rx_err == '0) |=> (err_flag == '0));

  assert_loop_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mctl_q[LOOP_BIT] |-> (ser_txd && (ser_rx_int == ser_tx_int)));
endmodule

bind sio_hostregs sio_hostregs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .rx_ready   (rx_ready),
  .rx_flush   (rx_flush),
  .rx_err     (rx_err),
  .ser_txd    (ser_txd),
  .ser_tx_int (ser_tx_int),
  .ser_rx_int (ser_rx_int),
  .lctl_q     (lctl_q),
  .mctl_q     (mctl_q),
  .ien_q      (ien_q),
  .spare_q    (spare_q),
  .dlo_q      (dlo_q),
  .dhi_q      (dhi_q),
  .err_flag   (err_flag)
);

// File: tb/sim_sio_hostregs.sv
`timescale 1ns/1ps
module sim_sio_hostregs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        tx_idle = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h3C;
  logic [3:0]  rx_err = '0;
  logic        rx_fifo_err = 1'b0;
  logic        fifo_en, rx_flush, tx_flush;
  logic [1:0]  rx_trig;
  logic [15:0] divisor;
  logic [1:0]  char_len;
  logic        stop_two, par_en, par_even, par_stick, brk;
  logic [3:0]  modem_in = '0;
  logic [3:0]  modem_ctl;
  logic        ser_tx_int = 1'b1;
  logic        ser_txd;
  logic        ser_rxd = 1'b1;
  logic        ser_rx_int;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sio_hostregs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; pop = rx_ready;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic p;
    rd(a, d, p);
    chk(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 ien", 3'd1, 8'h00);
    rd_chk("R1 ident", 3'd2, 8'h01);
    rd_chk("R1 lctl", 3'd3, 8'h00);
    rd_chk("R1 mctl", 3'd4, 8'h00);
    rd_chk("R1 lstat", 3'd5, 8'h60);
    rd_chk("R1 mstat", 3'd6, 8'h00);
    rd_chk("R1 spare", 3'd7, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 tx_valid", tx_valid, 1'b0);
    wr(3'd3, 8'h80);
    rd_chk("R1 div lo", 3'd0, 8'h00);
    rd_chk("R1 div hi", 3'd1, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_bank();
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk("R3 no push in bank", tx_valid, 1'b0);
    wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    rd_chk("R2 div lo", 3'd0, 8'h34);
    rd_chk("R2 div hi", 3'd1, 8'h12);
    rd_chk("R2 lctl", 3'd3, 8'h80);
    wr(3'd3, 8'h03);
    rd_chk("R2 ien bank0", 3'd1, 8'h00);
    wr(3'd1, 8'hFF);
    rd_chk("R13 ien width", 3'd1, 8'h0F);
    chk("R2 divisor kept", divisor, 16'h1234);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_push();
    tx_ready = 1'b1;
    wr(3'd0, 8'hA5);
    chk("R3 valid", tx_valid, 1'b1);
    chk("R3 data", tx_data, 8'hA5);
    idle(1);
    chk("R3 one cycle", tx_valid, 1'b0);
    tx_ready = 1'b0;
    wr(3'd0, 8'h5A);
    idle(2);
    chk("R3 held", tx_valid, 1'b1);
    chk("R3 held data", tx_data, 8'h5A);
    rd_chk("R8 holding busy", 3'd5, 8'h00);
    tx_ready = 1'b1;
    idle(1);
    chk("R3 accepted", tx_valid, 1'b0);
    rd_chk("R8 holding free", 3'd5, 8'h60);
  endtask

  task automatic t_pop();
    logic [7:0] d;
    logic p;
    rx_valid = 1'b1; rx_data = 8'h3C;
    rd(3'd0, d, p);
    chk("R4 data", d, 8'h3C);
    chk("R4 pop", p, 1'b1);
    rd(3'd7, d, p);
    chk("R4 no pop other", p, 1'b0);
    wr(3'd3, 8'h83);
    rd(3'd0, d, p);
    chk("R4 no pop bank", p, 1'b0);
    chk("R2 bank read", d, 8'h34);
    wr(3'd3, 8'h03);
    rx_valid = 1'b0;
  endtask

  task automatic t_fifo();
    wr(3'd2, 8'hC7);
    chk("R5 fifo_en", fifo_en, 1'b1);
    chk("R5 trig", rx_trig, 2'd3);
    chk("R5 rx_flush", rx_flush, 1'b1);
    chk("R5 tx_flush", tx_flush, 1'b1);
    idle(1);
    chk("R5 rx_flush pulse", rx_flush, 1'b0);
    chk("R5 tx_flush pulse", tx_flush, 1'b0);
    rd_chk("R5 ident fifo", 3'd2, 8'hC1);
    wr(3'd2, 8'h00);
    chk("R5 fifo off", fifo_en, 1'b0);
    rd_chk("R5 ident plain", 3'd2, 8'h01);
  endtask

  task automatic t_lctl();
    wr(3'd3, 8'h3B);
    chk("R6 len", char_len, 2'd3);
    chk("R6 stop", stop_two, 1'b0);
    chk("R6 par", {par_en, par_even, par_stick, brk}, 4'b1110);
    rd_chk("R6 lctl rb", 3'd3, 8'h3B);
    wr(3'd3, 8'h04);
    chk("R6 stop2", {stop_two, par_en, char_len}, 4'b1000);
    wr(3'd7, 8'h96);
    rd_chk("R6 spare rb", 3'd7, 8'h96);
    wr(3'd4, 8'h0A);
    chk("R6 modem_ctl", modem_ctl, 4'hA);
    rd_chk("R6 mctl rb", 3'd4, 8'h0A);
    wr(3'd4, 8'h00);
    idle(2);
    rd_chk("R9 clear", 3'd6, 8'h00);
  endtask

  task automatic t_ro();
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    idle(1);
    rd_chk("R7 lstat", 3'd5, 8'h60);
    rd_chk("R7 mstat", 3'd6, 8'h00);
    rd_chk("R7 lctl", 3'd3, 8'h04);
    rd_chk("R7 spare", 3'd7, 8'h96);
    chk("R7 divisor", divisor, 16'h1234);
    chk("R7 modem_ctl", modem_ctl, 4'h0);
  endtask

  task automatic t_lstat();
    @(negedge clk); rx_err = 4'b0101;
    @(negedge clk); rx_err = 4'b0000;
    rd_chk("R8 flags", 3'd5, 8'h6A);
    rd_chk("R8 cleared", 3'd5, 8'h60);
    rx_valid = 1'b1; rx_fifo_err = 1'b1;
    rd_chk("R8 ready+qerr", 3'd5, 8'hE1);
    rx_valid = 1'b0; rx_fifo_err = 1'b0;
  endtask

  task automatic t_mstat();
    modem_in = 4'b0001; idle(2);
    rd_chk("R9 cts rise", 3'd6, 8'h11);
    rd_chk("R9 cts cleared", 3'd6, 8'h10);
    modem_in = 4'b0000; idle(2);
    rd_chk("R9 cts fall", 3'd6, 8'h01);
    modem_in = 4'b0100; idle(2);
    rd_chk("R9 ri rise", 3'd6, 8'h40);
    modem_in = 4'b0000; idle(2);
    rd_chk("R9 ri fall", 3'd6, 8'h04);
    rd_chk("R9 all clear", 3'd6, 8'h00);
  endtask

  task automatic t_loop();
    chk("R11 txd", ser_txd, 1'b1);
    ser_rxd = 1'b0; #1;
    chk("R11 rx path", ser_rx_int, 1'b0);
    ser_rxd = 1'b1;
    wr(3'd4, 8'h1F);
    idle(1);
    chk("R10 modem_ctl off", modem_ctl, 4'h0);
    ser_tx_int = 1'b0; #1;
    chk("R10 txd high", ser_txd, 1'b1);
    chk("R10 looped low", ser_rx_int, 1'b0);
    ser_tx_int = 1'b1; #1;
    chk("R10 looped high", ser_rx_int, 1'b1);
    rd_chk("R10 mstat loop", 3'd6, 8'hFB);
    rd_chk("R10 mstat loop clr", 3'd6, 8'hF0);
    wr(3'd4, 8'h0F);
    idle(1);
    chk("R11 modem_ctl", modem_ctl, 4'hF);
    rd_chk("R10 mstat exit", 3'd6, 8'h0F);
    rd_chk("R10 mstat exit clr", 3'd6, 8'h00);
    ser_tx_int = 1'b0; #1;
    chk("R11 txd follows", ser_txd, 1'b0);
    ser_tx_int = 1'b1;
    wr(3'd3, 8'h44);
    chk("R11 break", ser_txd, 1'b0);
    wr(3'd3, 8'h04);
    chk("R11 break off", ser_txd, 1'b1);
    wr(3'd4, 8'h00);
    idle(2);
    rd_chk("R9 drain", 3'd6, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    logic p;
    rd(3'd5, d, p);
    rd(3'd6, d, p);
    wr(3'd1, 8'h0F);
    rd_chk("R12 thre", 3'd2, 8'h02);
    chk("R12 irq thre", irq, 1'b1);
    rx_valid = 1'b1;
    rd_chk("R12 rxd over thre", 3'd2, 8'h04);
    @(negedge clk); rx_err = 4'b0001;
    @(negedge clk); rx_err = 4'b0000;
    modem_in = 4'b0001; idle(2);
    rd_chk("R12 line first", 3'd2, 8'h06);
    rd_chk("R8 clear via read", 3'd5, 8'h63);
    rd_chk("R12 rxd next", 3'd2, 8'h04);
    rx_valid = 1'b0;
    rd_chk("R12 thre next", 3'd2, 8'h02);
    tx_ready = 1'b0;
    rd_chk("R12 modem last", 3'd2, 8'h00);
    chk("R12 irq modem", irq, 1'b1);
    rd_chk("R9 modem clear", 3'd6, 8'h11);
    rd_chk("R12 none", 3'd2, 8'h01);
    chk("R12 irq low", irq, 1'b0);
    tx_ready = 1'b1; rx_valid = 1'b1;
    wr(3'd1, 8'h00);
    rd_chk("R12 masked", 3'd2, 8'h01);
    chk("R12 irq masked", irq, 1'b0);
    rx_valid = 1'b0; modem_in = 4'b0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank();
    t_push();
    t_pop();
    t_fifo();
    t_lctl();
    t_ro();
    t_lstat();
    t_mstat();
    t_loop();
    t_irq();
    idle(2);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end
endmodule